// File: doc/BRIEF.md
# Video Playback Pixel Expander

The block takes YUV 4:2:2 bytes from a first-word-fall-through FIFO and places them on a byte-wide video output. Output slots are timed by the line-locked clock. They are anchored to a horizontal sync edge whose polarity software selects. A 10-bit offset sets how many cycles pass after that edge before the first slot opens. From then on, every cycle is an output slot until the next selected sync edge arrives.

Each fetched sample can be sent 1, 2, 4 or 8 times, which gives horizontal upscaling by repetition. In the two direct modes, a per-cycle qualifier marks slots that take no new data. Depending on the mode, such a slot either repeats the byte that was last put on the output or carries a fixed grey code. Slot positions alternate chroma and luma (Cb, Y, Cr, Y), starting with chroma at the first slot of a line. If the FIFO runs dry when a fetch is due, the slot is grey-filled and a sticky underflow flag is raised.

Top module: `vid_pixel_expander`

## Requirements
- R1: While `rst` is high on a clock edge, `vout_valid`, `fifo_rd`, `underflow` and `vout_data` are all zero after that edge.
- R2: The selected sync edge is the cycle in which `hsync` first equals `cfg_hs_pol`. The first output slot is the (`cfg_offset`+1)-th cycle after that cycle. Each slot's byte shows on `vout_data` with `vout_valid` high one cycle after the slot.
- R3: The repetition code `cfg_rep` sends each fetched sample 1 time (000), 2 times (001), 4 times (011) or 8 times (111) on consecutive qualified slots. The reserved codes 010, 100, 101 and 110 behave as 000.
- R4: `fifo_rd` is high only in a qualified slot where the previous sample has been sent its full count and `fifo_empty` is low. The `fifo_data` of that cycle is the next output byte.
- R5: In line-memory mode (`cfg_mode`=00) and field-memory mode (01), `qual` is ignored and every slot counts as qualified.
- R6: In mode 10, an unqualified slot repeats the byte last placed on `vout_data`, reads nothing and does not advance the repetition count.
- R7: In mode 11, an unqualified slot carries 0x80 on a chroma position and 0x10 on a luma position. Positions alternate on every slot, starting with chroma at the first slot after a sync edge.
- R8: When a fetch is due and `fifo_empty` is high, the slot carries the grey code for its position, nothing is read, and `underflow` goes high and stays high until reset.
- R9: With `cfg_fmt` other than 00 (YUV 4:2:2), no slot opens: `vout_valid` and `fifo_rd` stay low.
- R10: A selected sync edge ends the current line's slots, restarts the offset count and resets position and repetition. `cfg_hs_pol`=1 selects the rising edge and 0 the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync | input | 1 | Horizontal sync |
| cfg_hs_pol | input | 1 | Sync edge select: 1 rising, 0 falling |
| cfg_offset | input | 10 | Cycles from sync edge to first slot |
| cfg_rep | input | 3 | Sample repetition code |
| cfg_mode | input | 2 | 00 line, 01 field, 10 direct/repeat fill, 11 direct/grey fill |
| cfg_fmt | input | 2 | Output format, 00 = YUV 4:2:2 |
| qual | input | 1 | Per-slot qualifier (direct modes) |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_data | input | 8 | FIFO head byte (fall-through) |
| fifo_rd | output | 1 | Pop FIFO head this cycle |
| vout_data | output | 8 | Output byte |
| vout_valid | output | 1 | Output byte is a slot result |
| underflow | output | 1 | Sticky FIFO underflow flag |

## Verification
Every slot's byte is due exactly one cycle after its slot. The first valid byte of a line is due `cfg_offset`+2 rising edges after the edge that first sees the sync transition. The driver applies `hsync` and `qual` on falling edges, so each `qual` value lines up with the slot cycle the bench has computed. The monitor samples `vout_valid`, `vout_data` and `underflow` on falling edges, pops the expected byte from the scoreboard for each valid cycle, and checks the first one's arrival cycle against the offset. FIFO pops follow the `fifo_rd` seen at the rising edge. The end-of-line checks on queue and FIFO levels wait two cycles after the last slot, so they run after the final byte has been compared.

// File: rtl/vpx_pkg.sv
package vpx_pkg;

  typedef enum logic [1:0] {
    MODE_LINE      = 2'b00,
    MODE_FIELD     = 2'b01,
    MODE_DIR_REP   = 2'b10,
    MODE_DIR_GREY  = 2'b11
  } fill_mode_e;

  localparam logic [1:0] FMT_YUV422   = 2'b00;
  localparam logic [7:0] GREY_LUMA_8   = 8'h10;
  localparam logic [7:0] GREY_CHROMA_8 = 8'h80;
  localparam int         REP_CNT_W     = 3;

  // repetition code -> (number of sends - 1); reserved codes send once
  function automatic logic [REP_CNT_W-1:0] rep_extra(input logic [2:0] code);
    logic [REP_CNT_W-1:0] r;
    case (code)
      3'b001:  r = REP_CNT_W'(1);
      3'b011:  r = REP_CNT_W'(3);
      3'b111:  r = REP_CNT_W'(7);
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/vpx_line_timer.sv
module vpx_line_timer #(
  parameter int OFS_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hsync,
  input  logic             hs_pol,
  input  logic             run_en,
  input  logic [OFS_W-1:0] offset,
  output logic             line_start,
  output logic             slot_open
);

  logic             hs_q;
  logic             armed;
  logic             running;
  logic [OFS_W-1:0] cnt;
  logic             at_start;

  assign line_start = (hsync == hs_pol) && (hs_q != hs_pol);
  assign at_start   = armed && (cnt == '0);
  assign slot_open  = run_en && !line_start && (running || at_start);

  always_ff @(posedge clk) begin
    hs_q <= hsync;
    if (rst) begin
      armed   <= 1'b0;
      running <= 1'b0;
      cnt     <= '0;
    end else if (line_start) begin
      armed   <= 1'b1;
      running <= 1'b0;
      cnt     <= offset;
    end else if (at_start) begin
      armed   <= 1'b0;
      running <= 1'b1;
    end else if (armed) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/vpx_rep_ctrl.sv
module vpx_rep_ctrl
  import vpx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       line_start,
  input  logic       slot_open,
  input  logic       eff_qual,
  input  logic       fifo_empty,
  input  logic [2:0] rep_code,
  output logic       fetch,
  output logic       starve
);

  logic [REP_CNT_W-1:0] rep_left;
  logic                 need;

  assign need   = slot_open && eff_qual && (rep_left == '0);
  assign fetch  = need && !fifo_empty;
  assign starve = need && fifo_empty;

  always_ff @(posedge clk) begin
    if (rst || line_start) begin
      rep_left <= '0;
    end else if (fetch) begin
      rep_left <= rep_extra(rep_code);
    end else if (slot_open && eff_qual && (rep_left != '0)) begin
      rep_left <= rep_left - 1'b1;
    end
  end

endmodule

// File: rtl/vpx_out_stage.sv
module vpx_out_stage
  import vpx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_start,
  input  logic          slot_open,
  input  logic          eff_qual,
  input  logic          fetch,
  input  logic          starve,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] fifo_data,
  output logic [DW-1:0] vout_data,
  output logic          vout_valid,
  output logic          underflow
);

  localparam logic [DW-1:0] G_LUMA   = DW'(GREY_LUMA_8)   << (DW - 8);
  localparam logic [DW-1:0] G_CHROMA = DW'(GREY_CHROMA_8) << (DW - 8);

  logic          luma_pos;
  logic [DW-1:0] held;
  logic [DW-1:0] grey;
  logic [DW-1:0] next_byte;

  assign grey = luma_pos ? G_LUMA : G_CHROMA;

  always_comb begin
    if (fetch)                                next_byte = fifo_data;
    else if (starve)                          next_byte = grey;
    else if (eff_qual)                        next_byte = held;
    else if (fill_mode_e'(mode) == MODE_DIR_REP) next_byte = vout_data;
    else                                      next_byte = grey;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vout_data  <= '0;
      vout_valid <= 1'b0;
      luma_pos   <= 1'b0;
      held       <= '0;
      underflow  <= 1'b0;
    end else begin
      vout_valid <= slot_open;
      if (line_start) begin
        luma_pos <= 1'b0;
      end else if (slot_open) begin
        vout_data <= next_byte;
        luma_pos  <= ~luma_pos;
      end
      if (fetch)  held      <= fifo_data;
      if (starve) underflow <= 1'b1;
    end
  end

endmodule

// File: rtl/vid_pixel_expander.sv
module vid_pixel_expander
  import vpx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OFS_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync,
  input  logic              cfg_hs_pol,
  input  logic [OFS_W-1:0]  cfg_offset,
  input  logic [2:0]        cfg_rep,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_fmt,
  input  logic              qual,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_rd,
  output logic [DATA_W-1:0] vout_data,
  output logic              vout_valid,
  output logic              underflow
);

  logic line_start;
  logic slot_open;
  logic eff_qual;
  logic fetch;
  logic starve;
  logic direct;

  assign direct   = (fill_mode_e'(cfg_mode) == MODE_DIR_REP) ||
                    (fill_mode_e'(cfg_mode) == MODE_DIR_GREY);
  assign eff_qual = direct ? qual : 1'b1;
  assign fifo_rd  = fetch;

  vpx_line_timer #(.OFS_W(OFS_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .hsync      (hsync),
    .hs_pol     (cfg_hs_pol),
    .run_en     (cfg_fmt == FMT_YUV422),
    .offset     (cfg_offset),
    .line_start (line_start),
    .slot_open  (slot_open)
  );

  vpx_rep_ctrl u_rep (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .slot_open  (slot_open),
    .eff_qual   (eff_qual),
    .fifo_empty (fifo_empty),
    .rep_code   (cfg_rep),
    .fetch      (fetch),
    .starve     (starve)
  );

  vpx_out_stage #(.DW(DATA_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .slot_open  (slot_open),
    .eff_qual   (eff_qual),
    .fetch      (fetch),
    .starve     (starve),
    .mode       (cfg_mode),
    .fifo_data  (fifo_data),
    .vout_data  (vout_data),
    .vout_valid (vout_valid),
    .underflow  (underflow)
  );

endmodule

// File: rtl/vpx_checker.sv
module vpx_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          slot_open,
  input logic          qual,
  input logic [1:0]    cfg_mode,
  input logic [1:0]    cfg_fmt,
  input logic          fifo_empty,
  input logic [DW-1:0] fifo_data,
  input logic          fifo_rd,
  input logic [DW-1:0] vout_data,
  input logic          vout_valid,
  input logic          underflow
);

  localparam logic [DW-1:0] CK_LUMA   = DW'(8'h10) << (DW - 8);
  localparam logic [DW-1:0] CK_CHROMA = DW'(8'h80) << (DW - 8);

  assert_no_read_empty_R4: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> !fifo_empty);

  assert_read_to_output_R4: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |=> (vout_valid && vout_data == $past(fifo_data)));

  assert_slot_to_valid_R2: assert property (@(posedge clk) disable iff (rst)
    slot_open |=> vout_valid);

  assert_repeat_fill_R6: assert property (@(posedge clk) disable iff (rst)
    (slot_open && cfg_mode == 2'b10 && !qual) |=> $stable(vout_data));

  assert_grey_fill_R7: assert property (@(posedge clk) disable iff (rst)
    (slot_open && cfg_mode == 2'b11 && !qual) |=>
      (vout_data == CK_LUMA || vout_data == CK_CHROMA));

  assert_sticky_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);

  assert_fmt_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_fmt != 2'b00) |-> (!fifo_rd && !slot_open));

endmodule

bind vid_pixel_expander vpx_checker #(.DW(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .slot_open  (slot_open),
  .qual       (qual),
  .cfg_mode   (cfg_mode),
  .cfg_fmt    (cfg_fmt),
  .fifo_empty (fifo_empty),
  .fifo_data  (fifo_data),
  .fifo_rd    (fifo_rd),
  .vout_data  (vout_data),
  .vout_valid (vout_valid),
  .underflow  (underflow)
);

// File: tb/vid_pixel_expander_bench.sv
module vid_pixel_expander_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hsync = 1'b0;
  logic       cfg_hs_pol = 1'b1;
  logic [9:0] cfg_offset = '0;
  logic [2:0] cfg_rep = '0;
  logic [1:0] cfg_mode = '0;
  logic [1:0] cfg_fmt = 2'b01;
  logic       qual = 1'b0;
  logic       fifo_empty = 1'b1;
  logic [7:0] fifo_data = '0;
  logic       fifo_rd;
  logic [7:0] vout_data;
  logic       vout_valid;
  logic       underflow;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int t0 = 0;
  int first_ofs = 0;
  bit expect_first = 0;
  bit rd_seen = 0;
  bit exp_under = 0;
  logic [7:0] last_out = 8'h00;

  logic [7:0] fifo_q[$];
  logic [7:0] exp_q[$];
  string      exp_tag[$];
  logic [7:0] stage_bytes[$];
  bit         stage_qual[$];

  vid_pixel_expander u_vid_pixel_expander (
    .clk(clk), .rst(rst), .hsync(hsync), .cfg_hs_pol(cfg_hs_pol),
    .cfg_offset(cfg_offset), .cfg_rep(cfg_rep), .cfg_mode(cfg_mode),
    .cfg_fmt(cfg_fmt), .qual(qual), .fifo_empty(fifo_empty),
    .fifo_data(fifo_data), .fifo_rd(fifo_rd), .vout_data(vout_data),
    .vout_valid(vout_valid), .underflow(underflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    rd_seen <= fifo_rd;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fifo_refresh();
    fifo_empty = (fifo_q.size() == 0);
    fifo_data  = (fifo_q.size() == 0) ? 8'h00 : fifo_q[0];
  endtask

  // FIFO model: pop what the design read at the last rising edge
  always @(negedge clk) begin
    if (rd_seen && fifo_q.size() > 0) begin
      void'(fifo_q.pop_front());
      fifo_refresh();
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && vout_valid) begin
      if (expect_first) begin
        chk("R2 first-slot timing", cyc - t0, first_ofs + 2);
        expect_first = 0;
      end
      if (exp_q.size() == 0) begin
        chk("R9 unexpected output byte", 1, 0);
      end else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        chk(t, vout_data, e);
      end
    end
  end

  function automatic int sends(input logic [2:0] code);
    case (code)
      3'b001:  return 2;
      3'b011:  return 4;
      3'b111:  return 8;
      default: return 1;
    endcase
  endfunction

  // one line: stage_bytes feed the FIFO, stage_qual gives one qualifier per slot
  task automatic run_line(input logic [1:0] mode, input logic [2:0] rep,
                          input int ofs, input logic pol, input string tag);
    int avail;
    int bi;
    int remain;
    int nslot;
    logic [7:0] cur;
    avail  = stage_bytes.size();
    bi     = 0;
    remain = 0;
    cur    = 8'h00;
    nslot  = stage_qual.size();
    cfg_mode   = mode;
    cfg_rep    = rep;
    cfg_offset = 10'(ofs);
    cfg_hs_pol = pol;
    hsync      = ~pol;
    foreach (stage_bytes[k]) fifo_q.push_back(stage_bytes[k]);
    fifo_refresh();
    for (int i = 0; i < nslot; i++) begin
      logic [7:0] g;
      logic [7:0] o;
      bit eq;
      g  = (i % 2 == 1) ? 8'h10 : 8'h80;
      eq = mode[1] ? stage_qual[i] : 1'b1;
      if (eq) begin
        if (remain == 0) begin
          if (bi < avail) begin
            cur = stage_bytes[bi];
            bi++;
            o = cur;
            remain = sends(rep) - 1;
          end else begin
            o = g;
            exp_under = 1;
          end
        end else begin
          o = cur;
          remain--;
        end
      end else if (mode == 2'b10) begin
        o = last_out;
      end else begin
        o = g;
      end
      last_out = o;
      exp_q.push_back(o);
      exp_tag.push_back(tag);
    end
    @(negedge clk);
    expect_first = 1;
    first_ofs    = ofs;
    t0           = cyc;
    hsync        = pol;
    cfg_fmt      = 2'b00;
    qual         = 1'b0;
    for (int j = 1; j <= ofs + 1; j++) @(negedge clk);
    qual = stage_qual[0];
    for (int i = 1; i < nslot; i++) begin
      @(negedge clk);
      qual = stage_qual[i];
    end
    @(negedge clk);
    cfg_fmt = 2'b01;
    qual    = 1'b0;
    repeat (2) @(negedge clk);
    chk({tag, " all bytes delivered"}, exp_q.size(), 0);
    chk("R4 fifo level after line", fifo_q.size(), avail - bi);
    stage_bytes.delete();
    stage_qual.delete();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 vout_valid", vout_valid, 0);
    chk("R1 fifo_rd", fifo_rd, 0);
    chk("R1 underflow", underflow, 0);
    chk("R1 vout_data", vout_data, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R5: qualifier ignored in line-memory mode
    stage_bytes = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    stage_qual  = '{0, 0, 0, 0};
    run_line(2'b00, 3'b000, 5, 1'b1, "R5 line mode");

    // R3: repeat x2 in field-memory mode
    stage_bytes = '{8'h11, 8'h22, 8'h33};
    stage_qual  = '{1, 0, 1, 0, 1, 1};
    run_line(2'b01, 3'b001, 0, 1'b1, "R3 rep x2");

    stage_bytes = '{8'h44, 8'h55};
    stage_qual  = '{1, 1, 1, 1, 1, 1, 1, 1};
    run_line(2'b00, 3'b011, 3, 1'b1, "R3 rep x4");

    stage_bytes = '{8'h66};
    stage_qual  = '{1, 1, 1, 1, 1, 1, 1, 1};
    run_line(2'b00, 3'b111, 2, 1'b1, "R3 rep x8");

    stage_bytes = '{8'h77, 8'h88, 8'h99};
    stage_qual  = '{1, 1, 1};
    run_line(2'b00, 3'b010, 1, 1'b1, "R3 reserved rep code");

    // R6 with falling-edge sync (R10)
    stage_bytes = '{8'h5A, 8'h6B, 8'h7C, 8'h8D};
    stage_qual  = '{1, 0, 1, 1, 0, 0, 1};
    run_line(2'b10, 3'b000, 4, 1'b0, "R6 R10 repeat fill falling edge");

    stage_bytes = '{8'hC1, 8'hD2};
    stage_qual  = '{1, 0, 1, 1, 1};
    run_line(2'b10, 3'b001, 2, 1'b1, "R6 unqualified holds repetition");

    // R7 grey fill by position
    stage_bytes = '{8'hE1, 8'hF2};
    stage_qual  = '{0, 0, 1, 0, 1, 0};
    run_line(2'b11, 3'b000, 2, 1'b1, "R7 grey fill");

    chk("R8 no underflow before starvation", underflow, 0);
    stage_bytes = '{8'h31, 8'h42};
    stage_qual  = '{1, 1, 1, 1, 1};
    run_line(2'b00, 3'b000, 1, 1'b1, "R8 underflow grey");
    chk("R8 underflow flag", underflow, exp_under);

    // R9: reserved format, no slot opens
    @(negedge clk);
    cfg_mode = 2'b00;
    hsync    = 1'b0;
    fifo_q.push_back(8'hAB);
    fifo_refresh();
    @(negedge clk);
    cfg_fmt = 2'b10;
    hsync   = 1'b1;
    repeat (8) @(negedge clk);
    chk("R9 vout_valid idle", vout_valid, 0);
    chk("R9 no FIFO read", fifo_q.size(), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule